// File: doc/BRIEF.md
# Transition-Signalling Bus Codec

This block carries an N-bit data word across a long on-chip route as per-bit change events instead of levels. The transmit side compares each accepted word with the word it accepted before. It raises the wire of every bit that differs, for one clock cycle. The receive side keeps one toggle register per bit. It flips that register whenever the bit's wire is high in a cycle marked valid, so the data level is rebuilt at the far end. A wire whose bit holds its value never moves. An idle or unchanging bus therefore switches nothing, and every wire edge in a cycle goes one way only.

Both ends sit in one top module, and the encoded wires are brought out so their activity can be observed. A synchronous reset clears the transmit history and the receive registers to all zeros, so both ends start from the same level. An optional counter, chosen by a parameter, adds up every pulse seen on the wires. Its total can be compared with the toggle count a level-coded bus would have had.

The transmit side is a two-state machine. In TX_QUIET no word was accepted in the previous cycle and all wires are low. In TX_EMIT a word was accepted and the wires carry its change mask. TX_QUIET goes to TX_EMIT on a valid input. TX_EMIT stays on a valid input and falls back to TX_QUIET on an invalid one. The receive side mirrors this. RX_HOLD keeps the rebuilt word and signals no output. RX_SHOW presents a freshly updated word. RX_HOLD goes to RX_SHOW when the wires are marked valid, and RX_SHOW returns to RX_HOLD when they are not. Reset puts both machines in their quiet state.

Top module: `tsig_bus_codec`

## Requirements
- R1: While reset is high, and in the cycle after it, bus_pulse, bus_valid, out_data, out_valid and pulse_count are all zero. The transmit history restarts at all zeros.
- R2: One cycle after a valid input word, bus_valid is 1, and bus_pulse bit i is 1 exactly when data bit i differs from the previously accepted word (all zeros after reset).
- R3: One cycle after an input cycle with in_valid low, bus_pulse is all zeros and bus_valid is 0. So no wire stays high for more than one cycle unless its bit changes again.
- R4: A word presented with in_valid low has no effect. It does not update the transmit history, so a later valid word is compared with the last word that was accepted.
- R5: Two cycles after a valid input word, out_data equals that word.
- R6: out_valid equals bus_valid delayed by one cycle, which is in_valid delayed by two cycles.
- R7: out_data keeps its value in any cycle that follows one with bus_valid low.
- R8: With COUNT_EN=1, pulse_count rises by the number of ones on bus_pulse, one cycle after those ones appear. It does not change after a cycle with no pulses. With COUNT_EN=0 it is zero.
- R9: A valid word equal to the previously accepted word gives bus_pulse all zeros while bus_valid is 1, and out_data is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ends |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | WIDTH | Input data word |
| bus_pulse | output | WIDTH | Encoded wires, one change pulse per bit |
| bus_valid | output | 1 | Wires carry a word's change mask this cycle |
| out_data | output | WIDTH | Rebuilt data word |
| out_valid | output | 1 | out_data was updated from a valid bus cycle |
| pulse_count | output | CNT_W | Running total of bus pulses |

## Verification
The in-line assertions watch the cycle-level rules on every cycle. Wires must fall quiet after an idle input cycle, and no pulse may appear without bus_valid. out_valid must trail bus_valid by one cycle, out_data must hold after an invalid bus cycle, and the counter must stand still after a pulse-free cycle. Some behaviours can only be shown by the bench's scenarios: the exact change mask produced against the stored history, the rebuilt word matching the sent one, an invalid word not disturbing the history, restarting from zero after a mid-run reset, and the counter totals.

// File: rtl/tsig_pkg.sv
package tsig_pkg;

    typedef enum logic {
        TX_QUIET = 1'b0,
        TX_EMIT  = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_HOLD = 1'b0,
        RX_SHOW = 1'b1
    } rx_state_e;

endpackage

// File: rtl/tsig_encoder.sv
module tsig_encoder
    import tsig_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic [WIDTH-1:0] bus_pulse,
    output logic             bus_valid
);

    tx_state_e        state_q, state_d;
    logic [WIDTH-1:0] history_q;
    logic [WIDTH-1:0] pulse_q;
    logic [WIDTH-1:0] change_mask;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_QUIET;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_QUIET: if (in_valid)  state_d = TX_EMIT;
            TX_EMIT:  if (!in_valid) state_d = TX_QUIET;
            default:  state_d = TX_QUIET;
        endcase
    end

    // one XOR per wire: bit changed since last accepted word
    for (genvar b = 0; b < WIDTH; b++) begin : g_diff
        assign change_mask[b] = in_data[b] ^ history_q[b];
    end

    // history and pulse registers
    always_ff @(posedge clk) begin
        if (rst) begin
            history_q <= '0;
            pulse_q   <= '0;
        end else if (in_valid) begin
            history_q <= in_data;
            pulse_q   <= change_mask;
        end else begin
            pulse_q   <= '0;
        end
    end

    // outputs
    always_comb begin
        bus_pulse = pulse_q;
        bus_valid = (state_q == TX_EMIT);
    end

    // R3: idle input cycle leaves the wires low next cycle
    a_r3_quiet_after_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (bus_pulse == '0 && !bus_valid));

    // R2: a pulse only ever appears with bus_valid
    a_r2_pulse_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (bus_pulse != '0) |-> bus_valid);

    // R4: history untouched by invalid input
    a_r4_history_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(history_q));

endmodule

// File: rtl/tsig_decoder.sv
module tsig_decoder
    import tsig_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] bus_pulse,
    input  logic             bus_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid
);

    rx_state_e        state_q, state_d;
    logic [WIDTH-1:0] level_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_HOLD;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HOLD: if (bus_valid)  state_d = RX_SHOW;
            RX_SHOW: if (!bus_valid) state_d = RX_HOLD;
            default: state_d = RX_HOLD;
        endcase
    end

    // one toggle register per wire
    for (genvar b = 0; b < WIDTH; b++) begin : g_toggle
        always_ff @(posedge clk) begin
            if (rst)                           level_q[b] <= 1'b0;
            else if (bus_valid && bus_pulse[b]) level_q[b] <= ~level_q[b];
        end
    end

    always_comb begin
        out_data  = level_q;
        out_valid = (state_q == RX_SHOW);
    end

    // R6: receive valid trails bus valid by one cycle
    a_r6_valid_rise: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> out_valid);
    a_r6_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> !out_valid);

    // R7: rebuilt word holds after an invalid bus cycle
    a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> $stable(out_data));

endmodule

// File: rtl/tsig_activity_counter.sv
module tsig_activity_counter #(
    parameter int WIDTH    = 16,
    parameter int CNT_W    = 32,
    parameter bit COUNT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] bus_pulse,
    output logic [CNT_W-1:0] pulse_count
);

    localparam int PC_W = $clog2(WIDTH + 1);

    if (COUNT_EN) begin : g_count
        logic [CNT_W-1:0] total_q;
        logic [PC_W-1:0]  ones;

        always_comb begin
            ones = '0;
            for (int b = 0; b < WIDTH; b++) ones = ones + PC_W'(bus_pulse[b]);
        end

        always_ff @(posedge clk) begin
            if (rst) total_q <= '0;
            else     total_q <= total_q + CNT_W'(ones);
        end

        assign pulse_count = total_q;

        // R8: no pulses, no count change
        a_r8_idle_count: assert property (@(posedge clk) disable iff (rst)
            (bus_pulse == '0) |=> $stable(pulse_count));
    end else begin : g_nocount
        assign pulse_count = '0;
    end

endmodule

// File: rtl/tsig_bus_codec.sv
module tsig_bus_codec #(
    parameter int WIDTH    = 16,
    parameter int CNT_W    = 32,
    parameter bit COUNT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic [WIDTH-1:0] bus_pulse,
    output logic             bus_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid,
    output logic [CNT_W-1:0] pulse_count
);

    tsig_encoder #(.WIDTH(WIDTH)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .bus_pulse (bus_pulse),
        .bus_valid (bus_valid)
    );

    tsig_decoder #(.WIDTH(WIDTH)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .bus_pulse (bus_pulse),
        .bus_valid (bus_valid),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    tsig_activity_counter #(
        .WIDTH    (WIDTH),
        .CNT_W    (CNT_W),
        .COUNT_EN (COUNT_EN)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .bus_pulse   (bus_pulse),
        .pulse_count (pulse_count)
    );

    // R1: the cycle after reset everything is at its zero state
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (bus_pulse == '0 && !bus_valid && out_data == '0 && !out_valid));

endmodule

// File: tb/test_tsig_bus_codec.sv
module test_tsig_bus_codec;

    localparam int W = 16;
    localparam int C = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [W-1:0] bus_pulse;
    logic         bus_valid;
    logic [W-1:0] out_data;
    logic         out_valid;
    logic [C-1:0] pulse_count;

    int checks = 0;
    int fails  = 0;
    bit mon_on = 1'b0;

    logic [W-1:0] mask_q[$];
    logic [W-1:0] data_q[$];
    logic [W-1:0] sent_prev = '0;
    logic [C-1:0] cnt_exp = '0;
    logic         v1 = 1'b0, v2 = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tsig_bus_codec #(.WIDTH(W), .CNT_W(C), .COUNT_EN(1'b1)) i_tsig_bus_codec (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .bus_pulse(bus_pulse), .bus_valid(bus_valid), .out_data(out_data),
        .out_valid(out_valid), .pulse_count(pulse_count)
    );

    task automatic check(input string req, input logic [C-1:0] act, input logic [C-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, pushes expectations for valid words
    task automatic drive(input logic v, input logic [W-1:0] d);
        @(posedge clk); #1;
        in_valid = v;
        in_data  = d;
        if (v) begin
            mask_q.push_back(d ^ sent_prev);
            data_q.push_back(d);
            sent_prev = d;
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; in_valid = 1'b0; mon_on = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        check("R1 bus_pulse", C'(bus_pulse), '0);
        check("R1 bus_valid", C'(bus_valid), '0);
        check("R1 out_data", C'(out_data), '0);
        check("R1 out_valid", C'(out_valid), '0);
        check("R1 pulse_count", pulse_count, '0);
        mask_q.delete(); data_q.delete();
        sent_prev = '0; cnt_exp = '0; v1 = 1'b0; v2 = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
    endtask

    // monitor: samples mid-cycle
    always @(negedge clk) begin
        if (mon_on) begin
            logic [W-1:0] m;
            check("R8 pulse_count", pulse_count, cnt_exp);
            check("R6 out_valid delay", C'(out_valid), C'(v2));
            if (bus_valid) begin
                if (mask_q.size() == 0) check("R2 unexpected bus_valid", 1, 0);
                else begin
                    m = mask_q.pop_front();
                    check("R2/R9 change mask", C'(bus_pulse), C'(m));
                    cnt_exp += C'($countones(m));
                end
            end else begin
                check("R3 wires low when not valid", C'(bus_pulse), '0);
            end
            if (out_valid) begin
                if (data_q.size() == 0) check("R5 unexpected out_valid", 1, 0);
                else check("R5 rebuilt word", C'(out_data), C'(data_q.pop_front()));
            end
            v2 = v1;
            v1 = in_valid;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        do_reset();

        // R2 from zero history, then several patterns
        drive(1, 16'h00A5);
        drive(1, 16'h00A4);
        drive(1, 16'hFF5B);
        drive(1, 16'h0000);
        drive(0, 16'h0000);
        // R9: repeat word -> no pulses
        drive(1, 16'h1234);
        drive(1, 16'h1234);
        drive(1, 16'h1234);
        // R4: invalid word ignored, history kept
        drive(0, 16'hFFFF);
        drive(0, 16'h0F0F);
        drive(1, 16'h1234);
        drive(1, 16'h1235);
        // R3/R6: alternating valid
        for (int k = 0; k < 20; k++) drive(k[0], W'(k * 16'h1357));
        // full inversions
        for (int k = 0; k < 8; k++) drive(1, k[0] ? 16'hFFFF : 16'h0000);
        drive(0, 0); drive(0, 0); drive(0, 0);

        // R7: out_data holds through idle cycles
        @(negedge clk); held = out_data;
        drive(0, 16'hBEEF); drive(0, 16'hCAFE);
        @(negedge clk);
        check("R7 out_data held", C'(out_data), C'(held));
        check("R7 out_data held value", C'(out_data), C'(16'hFFFF));

        // walking ones
        for (int k = 0; k < W; k++) drive(1, W'(1) << k);
        drive(0, 0); drive(0, 0); drive(0, 0);
        check("R8 total after walk", pulse_count, cnt_exp);

        // mid-run reset: R1 history restarts at zero
        do_reset();
        drive(1, 16'h8001);
        drive(0, 0); drive(0, 0); drive(0, 0);
        check("R1 restart count", pulse_count, C'(2));
        check("R5 restart word", C'(out_data), C'(16'h8001));

        check("R2 queue drained", C'(mask_q.size()), 0);
        check("R5 queue drained", C'(data_q.size()), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule